// File: doc/BRIEF.md
# Delta-Sigma ADC SPI Command Engine

This block is the SPI master that talks to a multichannel delta-sigma converter. A host offers one request at a time on a valid/ready handshake: a request kind, a 5-bit register address, a byte to write, a receive length and a decode-gap length. The engine frames the matching command bytes on MOSI, clocks in any reply bytes from MISO into a flat receive buffer, and pulses `done` as chip select returns high.

Register reads and writes send a two-byte command (opcode, then a zero count byte). The engine then holds the bus quiet for a programmable number of system-clock cycles, because the converter needs several of its own clock periods to decode the command before data moves. Conversion data reads send a single opcode and then receive a status-plus-samples block of programmable length. The serial clock idles low, MOSI changes on the rising SCLK edge, and MISO is sampled on the falling edge (SPI mode 1). The SCLK half period is a parameter counted in system clocks.

Top module: `adc_cmd_spi`

## Requirements
- R1: After reset `cs_n` is 1, `sclk` is 0, `mosi` is 0, `done` is 0, `req_ready` is 1 and `rx_data` is all zero.
- R2: `req_ready` is 1 only while no frame is in progress; a request offered while busy is not taken and leaves the running frame unchanged.
- R3: A frame starts with `cs_n` low and `sclk` low for HALF system cycles; each bit then lasts 2*HALF cycles, `sclk` high for the first HALF and low for the second, with `mosi` holding the bit, MSB first; MISO is sampled where `sclk` falls; in the cycle after the last bit's low half `cs_n` is 1 and `done` is 1 for exactly one cycle.
- R4: Request kinds 0 to 4 send one byte and receive none: kind 0 sends 0x06, 1 sends 0x08, 2 sends 0x0A, 3 sends 0x1A, 4 sends 0x11; `req_rxlen` and `gap_cycles` have no effect on them.
- R5: Kind 6 (register read) sends 0x20 OR address, then 0x00, then receives one byte into `rx_data[7:0]`; `req_rxlen` has no effect.
- R6: Kind 7 (register write) sends 0x40 OR address, then 0x00, then `req_wdata`, and receives nothing.
- R7: For kinds 6 and 7 exactly `gap_cycles` extra cycles with `cs_n` low, `sclk` low and `mosi` low follow the second byte's low half; 0 inserts none; the value is taken when the request is accepted, later changes have no effect.
- R8: Kind 5 (data read) sends 0x12 and then receives `req_rxlen` bytes, limited to MAX_RX; 0 receives none; received byte k lands in `rx_data[8k+7:8k]`.
- R9: `rx_data` is cleared when a request is accepted, so bytes not received in the latest frame read 0; `mosi` is 0 while bytes are received and outside the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request will be taken |
| req_kind | input | 3 | Request kind (see R4 to R8) |
| req_addr | input | 5 | Register address for kinds 6 and 7 |
| req_wdata | input | 8 | Value for register write |
| req_rxlen | input | LEN_W | Bytes to receive on data read |
| gap_cycles | input | GAP_W | Decode gap in system cycles |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the converter |
| cs_n | output | 1 | Active-low chip select |
| miso | input | 1 | Serial data from the converter |
| rx_data | output | 8*MAX_RX | Received bytes, byte k at bits 8k+7:8k |
| done | output | 1 | One-cycle pulse at frame end |

## Verification
A reference model in the bench builds the expected `cs_n`, `sclk`, `mosi`, `req_ready` and `done` for every cycle of each frame and compares them on every clock, and it checks the receive buffer when `done` is expected. Each single-byte opcode is framed with a nonzero gap and receive length, which shows those inputs are ignored outside their request kinds. Register reads run with gaps of 0, 1 and 4 and with the widest address, and register writes with a long gap and varied values; the gap input changes after acceptance, which shows that the value is latched. Data reads of 0, 3, full-length and over-length blocks, a refused request during a read, and a command after a full read each test a separate case: the length limit, the handshake and the buffer clearing.

// File: rtl/adc_cmd_spi.sv
module adc_cmd_spi #(
  parameter int HALF   = 2,
  parameter int MAX_RX = 27,
  parameter int LEN_W  = 5,
  parameter int GAP_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [2:0]            req_kind,
  input  logic [4:0]            req_addr,
  input  logic [7:0]            req_wdata,
  input  logic [LEN_W-1:0]      req_rxlen,
  input  logic [GAP_W-1:0]      gap_cycles,
  output logic                  sclk,
  output logic                  mosi,
  output logic                  cs_n,
  input  logic                  miso,
  output logic [8*MAX_RX-1:0]   rx_data,
  output logic                  done
);
  localparam int HW = $clog2(HALF + 1);
  localparam int BW = $clog2(MAX_RX + 4);

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_BIT, S_GAP} state_t;
  state_t state;

  logic [HW-1:0]    hcnt;
  logic [2:0]       bitn;
  logic [BW-1:0]    bidx, ntot, rx_idx;
  logic [1:0]       ntx;
  logic             is_reg;
  logic [GAP_W-1:0] gap_q, gcnt;
  logic [23:0]      txsr;
  logic [7:0]       rxsr;

  logic [7:0]    op_d;
  logic [1:0]    ntx_d;
  logic [BW-1:0] nrx_d;
  logic          reg_d;

  always_comb begin
    op_d  = 8'h00;
    ntx_d = 2'd1;
    nrx_d = '0;
    reg_d = 1'b0;
    case (req_kind)
      3'd0: op_d = 8'h06;
      3'd1: op_d = 8'h08;
      3'd2: op_d = 8'h0A;
      3'd3: op_d = 8'h1A;
      3'd4: op_d = 8'h11;
      3'd5: begin
        op_d  = 8'h12;
        nrx_d = (int'(req_rxlen) > MAX_RX) ? BW'(MAX_RX) : BW'(req_rxlen);
      end
      3'd6: begin
        op_d = {3'b001, req_addr}; ntx_d = 2'd2; nrx_d = BW'(1); reg_d = 1'b1;
      end
      default: begin
        op_d = {3'b010, req_addr}; ntx_d = 2'd3; reg_d = 1'b1;
      end
    endcase
  end

  wire half_end = (hcnt == HW'(HALF - 1));
  wire is_tx    = (bidx < BW'(ntx));
  assign rx_idx    = bidx - BW'(ntx);
  assign req_ready = (state == S_IDLE);
  assign mosi      = (state == S_BIT) && is_tx && txsr[23];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; hcnt <= '0; bitn <= '0; bidx <= '0; ntot <= '0;
      ntx <= '0; is_reg <= 1'b0; gap_q <= '0; gcnt <= '0;
      txsr <= '0; rxsr <= '0; rx_data <= '0;
      sclk <= 1'b0; cs_n <= 1'b1; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          state   <= S_LEAD;
          cs_n    <= 1'b0;
          hcnt    <= '0;
          bitn    <= '0;
          bidx    <= '0;
          txsr    <= {op_d, 8'h00, req_wdata};
          ntx     <= ntx_d;
          ntot    <= BW'(ntx_d) + nrx_d;
          is_reg  <= reg_d;
          gap_q   <= gap_cycles;
          rx_data <= '0;
        end
        S_LEAD: if (half_end) begin
          state <= S_BIT; sclk <= 1'b1; hcnt <= '0;
        end else hcnt <= hcnt + 1'b1;
        S_BIT: if (!half_end) hcnt <= hcnt + 1'b1;
        else begin
          hcnt <= '0;
          if (sclk) begin
            sclk <= 1'b0;
            rxsr <= {rxsr[6:0], miso};
          end else begin
            txsr <= {txsr[22:0], 1'b0};
            if (bitn != 3'd7) begin
              bitn <= bitn + 1'b1;
              sclk <= 1'b1;
            end else begin
              bitn <= '0;
              if (!is_tx) rx_data[rx_idx*8 +: 8] <= rxsr;
              if (bidx == ntot - 1'b1) begin
                state <= S_IDLE; cs_n <= 1'b1; done <= 1'b1;
              end else begin
                bidx <= bidx + 1'b1;
                if (is_reg && bidx == BW'(1) && gap_q != '0) begin
                  state <= S_GAP; gcnt <= '0;
                end else sclk <= 1'b1;
              end
            end
          end
        end
        S_GAP: if (gcnt == gap_q - 1'b1) begin
          state <= S_BIT; sclk <= 1'b1;
        end else gcnt <= gcnt + 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R3
  sclk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n) sclk |-> !cs_n);
  // R2
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n) !cs_n |-> !req_ready);
  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!cs_n && !sclk));
  // R3
  done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> (cs_n && $past(!cs_n)));
  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R7
  gap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_GAP) |-> (!sclk && !mosi && !cs_n));
  // R9
  mosi_frame_chk: assert property (@(posedge clk) disable iff (!rst_n) mosi |-> !cs_n);
endmodule

// File: tb/adc_cmd_spi_test.sv
module adc_cmd_spi_test;
  localparam int HALF = 2, MAXRX = 27, LW = 5, GW = 8;
  localparam logic [4:0] IDLE_E = 5'b10100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [2:0] req_kind = '0;
  logic [4:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic [LW-1:0] req_rxlen = '0;
  logic [GW-1:0] gap_cycles = '0;
  logic sclk, mosi, cs_n, done;
  logic miso = 1'b0;
  logic [8*MAXRX-1:0] rx_data;

  int n_checks = 0, n_fail = 0, cyc = 0;
  logic [4:0] exp_q[$];
  string tag_q[$];
  logic [8*MAXRX-1:0] rx_q[$];
  bit slave_q[$];
  bit cur_ready = 1'b1;

  adc_cmd_spi #(.HALF(HALF), .MAX_RX(MAXRX), .LEN_W(LW), .GAP_W(GW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_rxlen(req_rxlen), .gap_cycles(gap_cycles), .sclk(sclk), .mosi(mosi),
    .cs_n(cs_n), .miso(miso), .rx_data(rx_data), .done(done));

  always #4 clk = ~clk;

  always @(posedge sclk) begin
    if (slave_q.size() > 0) miso <= slave_q.pop_front();
    else miso <= 1'b0;
  end

  function automatic logic [7:0] rbyte(int seed, int k);
    return 8'(seed * 37 + k * 101 + 13);
  endfunction

  task automatic check(bit ok, string tag, string what, logic [8*MAXRX-1:0] got, logic [8*MAXRX-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: got %h expected %h", tag, what, cyc, got, exp);
    end
  endtask

  task automatic tick();
    logic [4:0] e;
    string t;
    @(negedge clk);
    cyc++;
    if (exp_q.size() > 0) begin e = exp_q.pop_front(); t = tag_q.pop_front(); end
    else begin e = IDLE_E; t = "R2"; end
    check({req_ready, done, cs_n, sclk, mosi} === e, t, "ready/done/cs_n/sclk/mosi",
          (8*MAXRX)'({req_ready, done, cs_n, sclk, mosi}), (8*MAXRX)'(e));
    if (e[3]) begin
      logic [8*MAXRX-1:0] xr;
      xr = rx_q.pop_front();
      check(rx_data === xr, {t, "/R9"}, "rx_data", rx_data, xr);
    end
    cur_ready = e[4];
  endtask

  task automatic push(logic [4:0] e, string t, int n);
    for (int i = 0; i < n; i++) begin exp_q.push_back(e); tag_q.push_back(t); end
  endtask

  task automatic send(int kind, int addr, int wdata, int rxlen, int gap, int seed, string t);
    logic [7:0] txb[3];
    int ntx, nrx;
    logic [8*MAXRX-1:0] xr;
    while (!cur_ready || exp_q.size() > 0) tick();
    ntx = 1; nrx = 0;
    txb[1] = 8'h00; txb[2] = 8'(wdata);
    case (kind)
      0: txb[0] = 8'h06;
      1: txb[0] = 8'h08;
      2: txb[0] = 8'h0A;
      3: txb[0] = 8'h1A;
      4: txb[0] = 8'h11;
      5: begin txb[0] = 8'h12; nrx = (rxlen > MAXRX) ? MAXRX : rxlen; end
      6: begin txb[0] = 8'h20 | 8'(addr); ntx = 2; nrx = 1; end
      default: begin txb[0] = 8'h40 | 8'(addr); ntx = 3; end
    endcase
    xr = '0;
    push(5'b00000, t, HALF);
    for (int b = 0; b < ntx + nrx; b++) begin
      for (int i = 7; i >= 0; i--) begin
        bit m, s;
        m = (b < ntx) ? txb[b][i] : 1'b0;
        s = (b < ntx) ? 1'b1 : rbyte(seed, b - ntx)[i];
        slave_q.push_back(s);
        push({4'b0001, m}, t, HALF);
        push({4'b0000, m}, t, HALF);
      end
      if (b >= ntx) xr[(b - ntx)*8 +: 8] = rbyte(seed, b - ntx);
      if (kind >= 6 && b == 1) push(5'b00000, t, gap);
    end
    push(5'b11100, t, 1);
    rx_q.push_back(xr);
    req_kind = 3'(kind); req_addr = 5'(addr); req_wdata = 8'(wdata);
    req_rxlen = LW'(rxlen); gap_cycles = GW'(gap); req_valid = 1'b1;
    tick();
    req_valid = 1'b0;
    gap_cycles = GW'(gap + 7);
    req_rxlen = LW'(rxlen + 3);
  endtask

  task automatic drain();
    while (exp_q.size() > 0) tick();
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    tick();
    check({req_ready, done, cs_n, sclk, mosi} === IDLE_E && rx_data === '0, "R1", "reset state",
          (8*MAXRX)'({req_ready, done, cs_n, sclk, mosi}), (8*MAXRX)'(IDLE_E));
    tick();
    // R4 single-byte opcodes, rxlen and gap ignored
    for (int k = 0; k < 5; k++) begin send(k, 5'h1F, 8'hFF, 9, 5, k, "R4"); drain(); end
    // R3 plain frame timing
    send(1, 0, 0, 0, 0, 0, "R3"); drain();
    // R5 register reads
    send(6, 5'h05, 8'h00, 9, 4, 11, "R5"); drain();
    send(6, 5'h1F, 8'h3C, 0, 1, 12, "R5"); drain();
    // R7 gap variants
    send(6, 5'h01, 8'h00, 0, 0, 13, "R7"); drain();
    send(7, 5'h0A, 8'h5A, 0, 12, 14, "R7"); drain();
    // R6 register writes
    send(7, 5'h03, 8'hA5, 4, 4, 15, "R6"); drain();
    send(7, 5'h1E, 8'h81, 0, 3, 16, "R6"); drain();
    // R8 data reads
    send(5, 0, 0, 3, 6, 21, "R8"); drain();
    send(5, 0, 0, 27, 0, 22, "R8"); drain();
    send(5, 0, 0, 31, 0, 23, "R8"); drain();
    send(5, 0, 0, 0, 0, 24, "R8"); drain();
    // R2 request refused while busy
    send(5, 0, 0, 5, 0, 25, "R2");
    repeat (6) tick();
    req_kind = 3'd7; req_addr = 5'h02; req_wdata = 8'h77; req_valid = 1'b1;
    repeat (20) tick();
    req_valid = 1'b0;
    drain();
    // R9 buffer cleared by the next request
    send(5, 0, 0, 27, 0, 26, "R9"); drain();
    send(2, 0, 0, 0, 0, 0, "R9"); drain();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule